// File: doc/BRIEF.md
# Watchdog and Power-On Reset Sequencer

This block produces the reset for a processor from two sources: a flag that says whether the supply is above its threshold, and a watchdog that watches a three-level strobe input. While the supply is low, reset is held. Once the supply comes back, reset stays asserted for a fixed number of timebase ticks. The watchdog strobe is presented as a 2-bit code. If the strobe stays at one logic level for the whole watchdog window, the block raises a latched fault and also fires one fixed-length reset pulse. If the strobe is floating, the watchdog is switched off.

The block has four outputs: a low-line flag that tracks the supply directly, an active-low reset, its active-high complement, and an active-low watchdog fault. All periods are counted in ticks. A tick comes from one of two places. In internal mode it comes from a clock prescaler, and a second input then picks a short or long watchdog window. In external mode it comes from the rising edges of a tick input. The supply flag, the strobe code and the external tick each pass through a two-flop synchroniser before they are used.

Top module: `rst_supervisor`

## Requirements
- R1: While the synchronous block reset `rst` is high, `rst_n_o` is 0, `rst_o` is 1 and `wd_fault_n_o` is 1.
- R2: A low supply flag drives `rst_n_o` to 0 within two clock cycles, and reset stays asserted for as long as the flag stays low, whatever the number of ticks.
- R3: After the synchronised supply flag returns high, `rst_n_o` stays 0 through the first RST_TICKS-1 ticks and goes to 1 on tick number RST_TICKS.
- R4: `low_line_n_o` equals `supply_ok_i` delayed by exactly two clock cycles, with no dependence on ticks, and reset is asserted whenever `low_line_n_o` is 0.
- R5: When reset is released and the strobe code holds one level, 2'b00 (low) or 2'b01 (high), for a given number of ticks, `wd_fault_n_o` goes to 0 and reset is asserted for RST_TICKS ticks. That number is WD_EXT_TICKS in external mode, WD_FAST_TICKS in internal fast mode and WD_SLOW_TICKS in internal slow mode.
- R6: `wd_fault_n_o` stays 0 after the watchdog reset pulse ends, and returns to 1 three clock cycles after the next change of the strobe code.
- R7: A strobe code with bit 1 set (2'b10 or 2'b11 means floating) never produces a fault or a watchdog reset, and it keeps `wd_fault_n_o` at 1.
- R8: `rst_o` is always the inverse of `rst_n_o`.
- R9: With `tb_sel_i` = 1, one tick occurs every INT_DIV clock cycles and `wd_fast_i` selects the short window (1) or the long window (0). With `tb_sel_i` = 0, each rising edge of `ext_tick_i` is one tick. Both select inputs are treated as static configuration.
- R10: Any change of the strobe code clears the watchdog count. The count is also held at zero while reset is asserted, so a timeout needs the full window measured from the later of the last code change and the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok_i | input | 1 | 1 when the supply is above threshold (asynchronous) |
| wd_code_i | input | 2 | Watchdog strobe: 00 low, 01 high, 1x floating (asynchronous) |
| tb_sel_i | input | 1 | 1 selects internal prescaler, 0 selects external tick |
| wd_fast_i | input | 1 | Internal mode only: 1 short window, 0 long window |
| ext_tick_i | input | 1 | External tick, one tick per rising edge (asynchronous) |
| rst_n_o | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset |
| low_line_n_o | output | 1 | Active-low supply-low flag |
| wd_fault_n_o | output | 1 | Active-low latched watchdog fault |

## Verification
The assertions check invariants that hold on every cycle:
- Reset is asserted whenever the low-line flag is low.
- Reset is released only on a tick.
- A strobe edge clears the fault on the next cycle.
- A floating strobe never leaves a fault set.
- The watchdog count is held at zero while reset is asserted.
- Both counters stay within their bounds.

Only the bench scenarios can show the exact tick counts:
- the reset stretch after power returns and after a watchdog timeout;
- the three watchdog windows;
- the fact that the fault outlives the reset pulse;
- the fact that a supply dip restarts the watchdog window.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    typedef enum logic [1:0] {
        WD_LOW   = 2'b00,
        WD_HIGH  = 2'b01,
        WD_OPEN  = 2'b10,
        WD_OPEN2 = 2'b11
    } wd_code_e;

    typedef struct packed {
        logic internal;
        logic fast;
    } tb_cfg_t;

    function automatic logic wd_is_open(input logic [1:0] code);
        return code[1];
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rst_sup_tick.sv
module rst_sup_tick
    import rst_sup_pkg::*;
#(
    parameter int unsigned INT_DIV = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  tb_cfg_t cfg,
    input  logic    ext_s,
    output logic    tick_o
);
    localparam int unsigned DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(INT_DIV - 1);

    logic [DW-1:0] div_cnt;
    logic          ext_prev;
    logic          int_tick;
    logic          ext_tick;

    assign int_tick = (div_cnt == DIV_LAST);
    assign ext_tick = ext_s & ~ext_prev;
    assign tick_o   = cfg.internal ? int_tick : ext_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt  <= '0;
            ext_prev <= 1'b0;
        end else begin
            ext_prev <= ext_s;
            if (int_tick) div_cnt <= '0;
            else          div_cnt <= div_cnt + 1'b1;
        end
    end

    assert_div_range_R9: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= DIV_LAST);
endmodule

// File: rtl/rst_sup_wdog.sv
module rst_sup_wdog
    import rst_sup_pkg::*;
#(
    parameter int unsigned CW = 8,
    parameter int unsigned LIMIT_MAX = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    code_s,
    input  logic          tick,
    input  logic          hold_clr,
    input  logic [CW-1:0] limit,
    output logic          timeout_o,
    output logic          fault_n_o
);
    logic [1:0]    code_q;
    logic [CW-1:0] wd_cnt;
    logic          fault_q;
    logic          code_edge;
    logic          open_now;
    logic [CW:0]   cnt_next;

    assign code_edge = (code_s != code_q);
    assign open_now  = wd_is_open(code_s);
    assign cnt_next  = {1'b0, wd_cnt} + 1'b1;
    assign timeout_o = tick && !code_edge && !open_now && !hold_clr
                       && (cnt_next >= {1'b0, limit});
    assign fault_n_o = ~fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= WD_OPEN;
            wd_cnt  <= '0;
            fault_q <= 1'b0;
        end else begin
            code_q <= code_s;
            if (code_edge || open_now || hold_clr || timeout_o)
                wd_cnt <= '0;
            else if (tick)
                wd_cnt <= cnt_next[CW-1:0];
            if (code_edge)      fault_q <= 1'b0;
            else if (timeout_o) fault_q <= 1'b1;
        end
    end

    assert_edge_clears_fault_R6: assert property (@(posedge clk) disable iff (rst)
        code_edge |=> !fault_q);
    assert_open_no_fault_R7: assert property (@(posedge clk) disable iff (rst)
        (open_now && $past(open_now)) |-> !fault_q);
    assert_held_in_reset_R10: assert property (@(posedge clk) disable iff (rst)
        hold_clr |=> (wd_cnt == '0));
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
        32'(wd_cnt) <= LIMIT_MAX);
endmodule

// File: rtl/rst_sup_stretch.sv
module rst_sup_stretch #(
    parameter int unsigned RST_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_s,
    input  logic tick,
    input  logic wd_timeout,
    output logic active_o
);
    localparam int unsigned HW = $clog2(RST_TICKS + 1);
    localparam logic [HW-1:0] HOLD_FULL = HW'(RST_TICKS);

    logic [HW-1:0] hold_cnt;

    assign active_o = !supply_ok_s || (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)                                hold_cnt <= HOLD_FULL;
        else if (!supply_ok_s || wd_timeout)    hold_cnt <= HOLD_FULL;
        else if (tick && hold_cnt != '0)        hold_cnt <= hold_cnt - 1'b1;
    end

    assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> $past(tick));
    assert_hold_bound_R3: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= HOLD_FULL);
    assert_low_reload_R2: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_s |=> (hold_cnt == HOLD_FULL));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int unsigned INT_DIV       = 100000,
    parameter int unsigned RST_TICKS     = 200,
    parameter int unsigned WD_FAST_TICKS = 100,
    parameter int unsigned WD_SLOW_TICKS = 1600,
    parameter int unsigned WD_EXT_TICKS  = 1600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_i,
    input  logic [1:0] wd_code_i,
    input  logic       tb_sel_i,
    input  logic       wd_fast_i,
    input  logic       ext_tick_i,
    output logic       rst_n_o,
    output logic       rst_o,
    output logic       low_line_n_o,
    output logic       wd_fault_n_o
);
    localparam int unsigned LIMIT_MAX = max3(WD_FAST_TICKS, WD_SLOW_TICKS, WD_EXT_TICKS);
    localparam int unsigned CW        = $clog2(LIMIT_MAX + 1);

    tb_cfg_t       cfg;
    logic          supply_s;
    logic          ext_s;
    logic [1:0]    code_s;
    logic          tick;
    logic          wd_timeout;
    logic          rst_active;
    logic [CW-1:0] wd_limit;

    assign cfg.internal = tb_sel_i;
    assign cfg.fast     = wd_fast_i;

    always_comb begin
        if (!cfg.internal)  wd_limit = CW'(WD_EXT_TICKS);
        else if (cfg.fast)  wd_limit = CW'(WD_FAST_TICKS);
        else                wd_limit = CW'(WD_SLOW_TICKS);
    end

    rst_sup_sync #(.W(1), .RST_VAL(1'b0)) u_sync_supply (
        .clk(clk), .rst(rst), .d(supply_ok_i), .q(supply_s));

    rst_sup_sync #(.W(1), .RST_VAL(1'b0)) u_sync_tick (
        .clk(clk), .rst(rst), .d(ext_tick_i), .q(ext_s));

    rst_sup_sync #(.W(2), .RST_VAL(WD_OPEN)) u_sync_code (
        .clk(clk), .rst(rst), .d(wd_code_i), .q(code_s));

    rst_sup_tick #(.INT_DIV(INT_DIV)) u_tick (
        .clk(clk), .rst(rst), .cfg(cfg), .ext_s(ext_s), .tick_o(tick));

    rst_sup_wdog #(.CW(CW), .LIMIT_MAX(LIMIT_MAX)) u_wdog (
        .clk(clk), .rst(rst), .code_s(code_s), .tick(tick),
        .hold_clr(rst_active), .limit(wd_limit),
        .timeout_o(wd_timeout), .fault_n_o(wd_fault_n_o));

    rst_sup_stretch #(.RST_TICKS(RST_TICKS)) u_stretch (
        .clk(clk), .rst(rst), .supply_ok_s(supply_s), .tick(tick),
        .wd_timeout(wd_timeout), .active_o(rst_active));

    assign low_line_n_o = supply_s;
    assign rst_n_o      = ~rst_active;
    assign rst_o        = rst_active;

    assert_lowline_resets_R4: assert property (@(posedge clk) disable iff (rst)
        !low_line_n_o |-> !rst_n_o);
    assert_timeout_resets_R5: assert property (@(posedge clk) disable iff (rst)
        wd_timeout |=> (!rst_n_o && !wd_fault_n_o));
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
    localparam int unsigned DIV  = 8;
    localparam int unsigned RT   = 5;
    localparam int unsigned WDF  = 4;
    localparam int unsigned WDS  = 10;
    localparam int unsigned WDE  = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       supply_ok_i;
    logic [1:0] wd_code_i;
    logic       tb_sel_i;
    logic       wd_fast_i;
    logic       ext_tick_i;
    logic       rst_n_o, rst_o, low_line_n_o, wd_fault_n_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    rst_supervisor #(.INT_DIV(DIV), .RST_TICKS(RT), .WD_FAST_TICKS(WDF),
                     .WD_SLOW_TICKS(WDS), .WD_EXT_TICKS(WDE)) u_rst_supervisor (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i), .wd_code_i(wd_code_i),
        .tb_sel_i(tb_sel_i), .wd_fast_i(wd_fast_i), .ext_tick_i(ext_tick_i),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .low_line_n_o(low_line_n_o),
        .wd_fault_n_o(wd_fault_n_o));

    function automatic int exp_window(input bit internal, input bit fast);
        if (!internal) return WDE;
        return fast ? WDF : WDS;
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick_i = 1'b1; cyc(2);
            ext_tick_i = 1'b0; cyc(2);
        end
        cyc(3);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic toggle_level();
        wd_code_i = (wd_code_i == 2'b00) ? 2'b01 : 2'b00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t;
        int unused;
        unused = $urandom(32'd7741);
        rst = 1'b1; supply_ok_i = 1'b1; wd_code_i = 2'b00;
        tb_sel_i = 1'b0; wd_fast_i = 1'b0; ext_tick_i = 1'b0;
        cyc(3);
        chk("R1 rst_n", rst_n_o, 0);
        chk("R1 fault_n", wd_fault_n_o, 1);
        chk("R8 rst_o in reset", rst_o, 1);
        rst = 1'b0;
        cyc(4);
        chk("R4 low_line after sync", low_line_n_o, 1);
        chk("R3 no ticks yet", rst_n_o, 0);
        pulses(RT - 1);
        chk("R3 before last tick", rst_n_o, 0);
        pulses(1);
        chk("R3 released", rst_n_o, 1);
        chk("R8 rst_o released", rst_o, 0);

        // R10: random strobe toggling inside the window never times out
        for (int k = 0; k < 40; k++) begin
            toggle_level();
            cyc(3);
            pulses($urandom_range(0, WDE - 2));
            chk("R10 no fault with toggling", wd_fault_n_o, 1);
            chk("R10 no reset with toggling", rst_n_o, 1);
        end

        // R5 / R6: timeout in external mode
        toggle_level(); cyc(3);
        pulses(WDE - 1);
        chk("R5 one tick short", wd_fault_n_o, 1);
        pulses(1);
        chk("R5 fault", wd_fault_n_o, 0);
        chk("R5 reset", rst_n_o, 0);
        pulses(RT - 1);
        chk("R5 pulse still on", rst_n_o, 0);
        pulses(1);
        chk("R5 pulse ends", rst_n_o, 1);
        chk("R6 fault latched", wd_fault_n_o, 0);
        toggle_level();
        cyc(2);
        chk("R6 fault before sync", wd_fault_n_o, 0);
        cyc(1);
        chk("R6 fault cleared", wd_fault_n_o, 1);

        // R7: floating strobe
        wd_code_i = 2'b10; cyc(3);
        pulses(3 * WDE);
        chk("R7 float 10 fault", wd_fault_n_o, 1);
        chk("R7 float 10 reset", rst_n_o, 1);
        wd_code_i = 2'b11; cyc(3);
        pulses(2 * WDE);
        chk("R7 float 11 fault", wd_fault_n_o, 1);
        chk("R7 float 11 reset", rst_n_o, 1);

        // R2 / R4: supply dip
        supply_ok_i = 1'b0;
        cyc(1);
        chk("R4 low_line one cycle", low_line_n_o, 1);
        cyc(1);
        chk("R4 low_line two cycles", low_line_n_o, 0);
        chk("R2 reset on low supply", rst_n_o, 0);
        pulses(3 * RT);
        chk("R2 held while low", rst_n_o, 0);
        supply_ok_i = 1'b1;
        cyc(2);
        chk("R4 low_line returns", low_line_n_o, 1);
        chk("R3 still in reset", rst_n_o, 0);
        pulses(RT - 1);
        chk("R3 supply return short", rst_n_o, 0);
        pulses(1);
        chk("R3 supply return release", rst_n_o, 1);

        // R10: supply dip restarts the watchdog window
        wd_code_i = 2'b00; cyc(3);
        pulses(WDE - 2);
        supply_ok_i = 1'b0; cyc(4);
        supply_ok_i = 1'b1; cyc(3);
        pulses(RT);
        chk("R10 release after dip", rst_n_o, 1);
        pulses(WDE - 1);
        chk("R10 window restarted", wd_fault_n_o, 1);
        pulses(1);
        chk("R10 timeout after full window", wd_fault_n_o, 0);
        pulses(RT);
        toggle_level(); cyc(4);

        // R9: internal timebase, fast then slow
        for (int m = 1; m >= 0; m--) begin
            tb_sel_i = 1'b1; wd_fast_i = m[0];
            while (rst_n_o !== 1'b1) cyc(1);
            toggle_level();
            t = 0;
            while (wd_fault_n_o === 1'b1 && t < 300) begin cyc(1); t++; end
            chk_rng("R9 internal window", t, (exp_window(1, m[0]) - 1) * DIV + 2,
                    exp_window(1, m[0]) * DIV + 6);
            t = 0;
            while (rst_n_o !== 1'b1 && t < 300) begin cyc(1); t++; end
            chk_rng("R9 internal reset length", t, (RT - 1) * DIV, RT * DIV + 2);
            toggle_level(); cyc(4);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule